// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits in front of a PCI host bridge's configuration mechanism. Software selects a target device by writing a word in which a single bit in the upper part, from bit 11 to bit 31, acts as an IDSEL line. The block priority-encodes that bit into a 5-bit device number. It then stores a standard type-0 configuration address made of an enable bit, bus, device, function and register fields, and presents that address to the configuration data path. Reading the same port decodes the stored device number back into one-hot form, so software sees the selection in the format it wrote.

A parameter optionally swaps the byte lanes on both the write and the read path, for a CPU that stores words big-endian. A separate combinational swizzle routes the four interrupt pins of each slot onto four consecutive host interrupt lines. The pin-to-line mapping is rotated by the slot's device number, which spreads shared interrupts across the four lines.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset the stored address (`cfg_addr_out`) is 0x00000000, `no_dev_seen` is 0, and a read returns 0x00000001 (device 0 one-hot, all other fields clear), before any lane swap.
- R2: A write is accepted only in a cycle where both `reg_valid` and `reg_we` are 1. The new address appears on `cfg_addr_out` after that clock edge. Any other cycle leaves the stored address unchanged.
- R3: On an accepted write, the device field `cfg_addr_out[15:11]` takes the index of the lowest set bit among bits 11..31 of the (little-endian) write word. Set bits above that one are ignored.
- R4: The stored address has bit 31 set to 1, bits 30:24 set to 0, and bus field bits 23:16 set to 0. Bits 10:2 are copied from the write word and bits 1:0 are 0.
- R5: When bits 11..31 of the write word are all 0, the device field is loaded with 21 and `no_dev_seen` goes to 1. It stays 1 until reset, whatever is written later.
- R6: `reg_rdata` is combinational from the stored address. It returns a one-hot bit at position `cfg_addr_out[15:11]`, OR-ed with `cfg_addr_out[10:2]` in place at bits 10:2. Bits 1:0 read as 0 unless the one-hot bit falls there. During a write cycle it still shows the old value.
- R7: With `BIG_ENDIAN`=1 the write word is byte-reversed before decoding (byte 0 swaps with byte 3, byte 1 with byte 2). The read word is byte-reversed after encoding. `cfg_addr_out` is never swapped.
- R8: Interrupt pin p (0..3) of slot s, which holds device number `FIRST_DEV`+s and is input `slot_intx[4*s+p]`, drives `host_irq[IRQ_BASE + ((p + FIRST_DEV + s) mod 4)]`. Several pins that map to the same line are OR-ed together.
- R9: Bits of `host_irq` outside `IRQ_BASE`..`IRQ_BASE`+3 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Access strobe for the address port |
| reg_we | input | 1 | Write qualifier for the access |
| reg_wdata | input | 32 | CPU write word (one-hot device select) |
| reg_rdata | output | 32 | CPU read word, rebuilt in one-hot form |
| cfg_addr_out | output | 32 | Stored type-0 configuration address |
| no_dev_seen | output | 1 | Sticky flag: a write selected no device |
| slot_intx | input | 4*NUM_SLOTS | Interrupt pins of each slot, 4 per slot |
| host_irq | output | HOST_IRQ_W | Host interrupt controller inputs |

## Verification
A register write and the combinational read-back of the same port can fall in the same cycle. In that case the read must still show the address stored before the write, and the new one-hot value shows only after the edge. The bench holds a write strobe across a cycle and samples `reg_rdata` before the edge, where it expects the old value, then samples it again after the edge, where it expects the new one. The interrupt swizzle runs in parallel with register traffic. Pins are toggled while writes are in flight, and the host lines are judged only against the pin-and-slot mapping.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
   localparam int WORD_W    = 32;
   localparam int DEV_W     = 5;
   localparam int SCAN_LO   = 11;
   localparam int INTX_PINS = 4;
   localparam int BUS_W     = 8;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [DEV_W-1:0]  dev_t;
endpackage

// File: rtl/cfg_lane_swap.sv
module cfg_lane_swap
   import cfg_xlate_pkg::*;
#(
   parameter bit SWAP = 1'b0
) (
   input  word_t din,
   output word_t dout
);
   localparam int LANES = WORD_W / 8;

   generate
      if (SWAP) begin : g_swap
         for (genvar b = 0; b < LANES; b++) begin : g_lane
            assign dout[8*b +: 8] = din[8*(LANES-1-b) +: 8];
         end
      end else begin : g_pass
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/cfg_idsel_encode.sv
module cfg_idsel_encode
   import cfg_xlate_pkg::*;
#(
   parameter int MISS_CODE = 21
) (
   input  word_t wword,
   output dev_t  dev,
   output logic  hit
);
   always_comb begin
      dev = dev_t'(MISS_CODE);
      hit = 1'b0;
      // Walk down so that the lowest set bit is the last one assigned.
      for (int i = WORD_W - 1; i >= SCAN_LO; i--) begin
         if (wword[i]) begin
            dev = dev_t'(i);
            hit = 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfg_idsel_decode.sv
module cfg_idsel_decode
   import cfg_xlate_pkg::*;
(
   input  word_t addr,
   output word_t rword
);
   localparam int LOW_W = SCAN_LO - 2;
   word_t onehot;

   always_comb begin
      onehot = '0;
      onehot[addr[SCAN_LO +: DEV_W]] = 1'b1;
      rword  = onehot | {{(WORD_W-SCAN_LO){1'b0}}, addr[SCAN_LO-1:2], 2'b00};
   end

   generate
      if (LOW_W != 9) begin : g_bad_low
         $error("cfg_idsel_decode: field layout mismatch");
      end
   endgenerate
endmodule

// File: rtl/cfg_intx_swizzle.sv
module cfg_intx_swizzle
   import cfg_xlate_pkg::*;
#(
   parameter int NUM_SLOTS  = 4,
   parameter int FIRST_DEV  = 12,
   parameter int IRQ_BASE   = 8,
   parameter int HOST_IRQ_W = 16
) (
   input  logic [NUM_SLOTS*INTX_PINS-1:0] slot_intx,
   output logic [HOST_IRQ_W-1:0]          host_irq
);
   logic [NUM_SLOTS-1:0][INTX_PINS-1:0] rot;

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         for (genvar p = 0; p < INTX_PINS; p++) begin : g_pin
            localparam int LINE = (p + FIRST_DEV + s) % INTX_PINS;
            assign rot[s][LINE] = slot_intx[s*INTX_PINS + p];
         end
      end
   endgenerate

   always_comb begin
      host_irq = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         host_irq[IRQ_BASE +: INTX_PINS] = host_irq[IRQ_BASE +: INTX_PINS] | rot[s];
      end
   end
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
   import cfg_xlate_pkg::*;
#(
   parameter bit BIG_ENDIAN = 1'b0,
   parameter int MISS_CODE  = 21,
   parameter int BUS_NUM    = 0,
   parameter int NUM_SLOTS  = 4,
   parameter int FIRST_DEV  = 12,
   parameter int IRQ_BASE   = 8,
   parameter int HOST_IRQ_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_valid,
   input  logic                          reg_we,
   input  logic [31:0]                   reg_wdata,
   output logic [31:0]                   reg_rdata,
   output logic [31:0]                   cfg_addr_out,
   output logic                          no_dev_seen,
   input  logic [NUM_SLOTS*4-1:0]        slot_intx,
   output logic [HOST_IRQ_W-1:0]         host_irq
);
   localparam int PAD_W = WORD_W - 1 - BUS_W - DEV_W - (SCAN_LO - 2) - 2;

   generate
      if (IRQ_BASE + INTX_PINS > HOST_IRQ_W) begin : g_bad_irq
         $error("cfg_addr_xlate: interrupt window exceeds host_irq width");
      end
      if (MISS_CODE < 0 || MISS_CODE >= (1 << DEV_W)) begin : g_bad_miss
         $error("cfg_addr_xlate: MISS_CODE does not fit device field");
      end
      if (BUS_NUM < 0 || BUS_NUM >= (1 << BUS_W)) begin : g_bad_bus
         $error("cfg_addr_xlate: BUS_NUM does not fit bus field");
      end
      if (NUM_SLOTS < 1) begin : g_bad_slots
         $error("cfg_addr_xlate: need at least one slot");
      end
      if (PAD_W != 7) begin : g_bad_pad
         $error("cfg_addr_xlate: address layout mismatch");
      end
   endgenerate

   word_t wr_le;
   word_t rd_le;
   word_t addr_q;
   logic  nodev_q;
   dev_t  enc_dev;
   logic  enc_hit;
   logic  wr_en;

   assign wr_en = reg_valid & reg_we;

   cfg_lane_swap #(.SWAP(BIG_ENDIAN)) u_wr_swap (
      .din  (reg_wdata),
      .dout (wr_le)
   );

   cfg_idsel_encode #(.MISS_CODE(MISS_CODE)) u_enc (
      .wword (wr_le),
      .dev   (enc_dev),
      .hit   (enc_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         nodev_q <= 1'b0;
      end else if (wr_en) begin
         addr_q  <= {1'b1, {PAD_W{1'b0}}, BUS_W'(BUS_NUM), enc_dev,
                     wr_le[SCAN_LO-1:2], 2'b00};
         nodev_q <= nodev_q | ~enc_hit;
      end
   end

   cfg_idsel_decode u_dec (
      .addr  (addr_q),
      .rword (rd_le)
   );

   cfg_lane_swap #(.SWAP(BIG_ENDIAN)) u_rd_swap (
      .din  (rd_le),
      .dout (reg_rdata)
   );

   cfg_intx_swizzle #(
      .NUM_SLOTS  (NUM_SLOTS),
      .FIRST_DEV  (FIRST_DEV),
      .IRQ_BASE   (IRQ_BASE),
      .HOST_IRQ_W (HOST_IRQ_W)
   ) u_swz (
      .slot_intx (slot_intx),
      .host_irq  (host_irq)
   );

   assign cfg_addr_out = addr_q;
   assign no_dev_seen  = nodev_q;
endmodule

// File: rtl/cfg_addr_xlate_chk.sv
module cfg_addr_xlate_chk #(
   parameter int IRQ_BASE   = 8,
   parameter int HOST_IRQ_W = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_valid,
   input logic                  reg_we,
   input logic [31:0]           cfg_addr_out,
   input logic                  no_dev_seen,
   input logic [HOST_IRQ_W-1:0] host_irq
);
   localparam logic [HOST_IRQ_W-1:0] WIN = HOST_IRQ_W'(4'hF) << IRQ_BASE;

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (cfg_addr_out == 32'h0 && !no_dev_seen));

   assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_valid && reg_we) |=> $stable(cfg_addr_out));

   assert_fixed_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && reg_we) |=> (cfg_addr_out[31:16] == 16'h8000 && cfg_addr_out[1:0] == 2'b00));

   assert_nodev_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      no_dev_seen |=> no_dev_seen);

   assert_irq_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_irq & ~WIN) == '0);
endmodule

bind cfg_addr_xlate cfg_addr_xlate_chk #(
   .IRQ_BASE   (IRQ_BASE),
   .HOST_IRQ_W (HOST_IRQ_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_valid    (reg_valid),
   .reg_we       (reg_we),
   .cfg_addr_out (cfg_addr_out),
   .no_dev_seen  (no_dev_seen),
   .host_irq     (host_irq)
);

// File: tb/cfg_addr_xlate_bench.sv
module cfg_addr_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0, we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, addr;
   logic        nodev;
   logic [15:0] intx = '0;
   logic [15:0] hirq;

   logic        b_valid = 1'b0, b_we = 1'b0;
   logic [31:0] b_wdata = '0;
   logic [31:0] b_rdata, b_addr;
   logic        b_nodev;
   logic [15:0] b_hirq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cfg_addr_xlate u_cfg_addr_xlate (
      .clk(clk), .rst_n(rst_n), .reg_valid(valid), .reg_we(we), .reg_wdata(wdata),
      .reg_rdata(rdata), .cfg_addr_out(addr), .no_dev_seen(nodev),
      .slot_intx(intx), .host_irq(hirq));

   cfg_addr_xlate #(.BIG_ENDIAN(1'b1)) u_cfg_addr_xlate_be (
      .clk(clk), .rst_n(rst_n), .reg_valid(b_valid), .reg_we(b_we), .reg_wdata(b_wdata),
      .reg_rdata(b_rdata), .cfg_addr_out(b_addr), .no_dev_seen(b_nodev),
      .slot_intx(16'h0), .host_irq(b_hirq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk); valid = 1'b1; we = 1'b1; wdata = d;
      @(negedge clk); valid = 1'b0; we = 1'b0; wdata = '0;
   endtask

   task automatic t_reset;
      chk("R1 addr", addr, 32'h0);
      chk("R1 rdata", rdata, 32'h1);
      chk("R1 nodev", {31'b0, nodev}, 32'h0);
      chk("R1 be rdata", b_rdata, 32'h0100_0000);
   endtask

   task automatic t_basic;
      wr(32'h0000_0B0C);
      chk("R3 R4 addr bit11", addr, 32'h8000_5B0C);
      chk("R6 rdata bit11", rdata, 32'h0000_0B0C);
      wr(32'h0044_01F3);
      chk("R3 R4 lowest of two", addr, 32'h8000_91F0);
      chk("R6 rdata dev18", rdata, 32'h0004_01F0);
      wr(32'h8000_0004);
      chk("R3 addr bit31", addr, 32'h8000_F804);
      chk("R6 rdata dev31", rdata, 32'h8000_0004);
   endtask

   task automatic t_ignore;
      @(negedge clk); valid = 1'b1; we = 1'b0; wdata = 32'h0000_1000;
      @(negedge clk); valid = 1'b0; we = 1'b1;
      @(negedge clk); we = 1'b0; wdata = '0;
      chk("R2 no-commit addr", addr, 32'h8000_F804);
      chk("R2 no-commit rdata", rdata, 32'h8000_0004);
   endtask

   task automatic t_same_cycle;
      @(negedge clk); valid = 1'b1; we = 1'b1; wdata = 32'h0000_2008;
      #5 chk("R6 old value during write", rdata, 32'h8000_0004);
      @(negedge clk); valid = 1'b0; we = 1'b0; wdata = '0;
      chk("R6 new value after edge", rdata, 32'h0000_2008);
      chk("R3 dev13 addr", addr, 32'h8000_6808);
   endtask

   task automatic t_nodev;
      chk("R5 flag clear before", {31'b0, nodev}, 32'h0);
      wr(32'h0000_07FF);
      chk("R5 miss addr", addr, 32'h8000_AFFC);
      chk("R5 miss rdata", rdata, 32'h0020_07FC);
      chk("R5 flag set", {31'b0, nodev}, 32'h1);
      wr(32'h0000_0800);
      chk("R5 flag sticky", {31'b0, nodev}, 32'h1);
      chk("R3 after miss", addr, 32'h8000_5800);
   endtask

   task automatic t_swap;
      @(negedge clk); b_valid = 1'b1; b_we = 1'b1; b_wdata = 32'h0C0B_0000;
      @(negedge clk); b_valid = 1'b0; b_we = 1'b0;
      chk("R7 be addr unswapped", b_addr, 32'h8000_5B0C);
      chk("R7 be rdata swapped", b_rdata, 32'h0C0B_0000);
      chk("R7 be nodev", {31'b0, b_nodev}, 32'h0);
   endtask

   task automatic t_irq;
      intx = 16'h0010; #2 chk("R8 slot1 pin0", {16'b0, hirq}, 32'h0200);
      intx = 16'h0200; #2 chk("R8 slot2 pin1", {16'b0, hirq}, 32'h0800);
      intx = 16'h8000; #2 chk("R8 slot3 pin3", {16'b0, hirq}, 32'h0400);
      intx = 16'h0001; #2 chk("R8 slot0 pin0", {16'b0, hirq}, 32'h0100);
      intx = 16'h0000; #2 chk("R9 idle", {16'b0, hirq}, 32'h0000);
      intx = 16'hFFFF; #2 chk("R9 all pins", {16'b0, hirq}, 32'h0F00);
      wr(32'h0001_0000);
      chk("R8 irq during write", {16'b0, hirq}, 32'h0F00);
      intx = 16'h0000;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_ignore();
      t_same_cycle();
      t_nodev();
      t_swap();
      t_irq();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule